// File: doc/BRIEF.md
# Multi-Slope Exposure Pulse Generator

This block times the per-frame control pulses of a global-shutter pixel array. A frame-start strobe opens a frame. From then on the block counts clock cycles into line periods. A line period is a programmable row-overhead cycle count plus one cycle per pixel read on that line. Against the running line index it raises four pulses:

- a main reset pulse at the start of the frame;
- up to two extra reset pulses that add knee points to the pixel response, giving dual-slope and triple-slope operation;
- a frame-transfer pulse that closes the integration window.

Each event position is programmed as a line count minus one. The timing inputs are captured once, on the frame-start strobe. Software can therefore rewrite them during a frame without disturbing the frame in progress. If an extra reset is placed on or after the frame-transfer line, it could not shape the response, so the block drops that pulse and raises a configuration-error flag for the rest of the frame.

Top module: `expo_pulse_gen`

## Requirements
- R1: After reset, and until the first frame-start strobe, all six outputs (`line_tick`, `rst_pulse`, `ds_pulse`, `ts_pulse`, `xf_pulse`, `cfg_err`) are low.
- R2: A line period lasts `row_ovh_in + pix_cnt_in` cycles, or 1 cycle when that sum is 0. Line 0 begins in the cycle after the frame-start strobe is sampled. `line_tick` is high in the last cycle of every line.
- R3: `rst_pulse` is high during lines 0 through `rst_len_in - 2`, so it lasts `rst_len_in - 1` line periods.
- R4: A `rst_len_in` value of 0 or 1 behaves like 2, so the main reset covers exactly line 0.
- R5: `ds_pulse` is high for the whole of line `ds_pos_in - 1` and at no other time. A value of 0 disables it.
- R6: `ts_pulse` is high for the whole of line `ts_pos_in - 1` and at no other time. A value of 0 disables it.
- R7: `xf_pulse` is high for the whole of line `xf_pos_in - 1` and at no other time. A value of 0 disables it.
- R8: When `xf_pos_in` is nonzero and a nonzero slope position is greater than or equal to it, that slope pulse is suppressed for the frame. `cfg_err` is then high from the cycle after the frame-start strobe until the next strobe. Otherwise `cfg_err` is low.
- R9: Timing, overhead and pixel-count inputs are sampled only on the frame-start strobe. Changing them during a frame has no effect on that frame.
- R10: A frame-start strobe during a running frame restarts the frame from line 0, using the values presented with that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe that opens a frame and captures the settings |
| rst_len_in | input | 12 | Main reset length, in lines plus one |
| ds_pos_in | input | 12 | Dual-slope reset line plus one; 0 disables |
| ts_pos_in | input | 12 | Triple-slope reset line plus one; 0 disables |
| xf_pos_in | input | 12 | Frame-transfer line plus one; 0 disables |
| row_ovh_in | input | OVH_W | Row overhead cycles per line |
| pix_cnt_in | input | PIX_W | Pixel read cycles per line |
| rst_pulse | output | 1 | Main reset pulse |
| ds_pulse | output | 1 | Dual-slope reset pulse |
| ts_pulse | output | 1 | Triple-slope reset pulse |
| xf_pulse | output | 1 | Frame-transfer pulse |
| line_tick | output | 1 | High in the last cycle of each line |
| cfg_err | output | 1 | Slope reset suppressed in the current frame |

## Verification
The bench builds the block with its default widths of 8 bits for the overhead and pixel-count inputs. The vectors keep line periods between 1 and 5 cycles. Short lines put many line boundaries, and every event position, inside a few dozen cycles. They also reach the clamp of a zero-length line to one cycle and the clamp of a reset length below two. Slope positions that equal or exceed the transfer position exercise the suppression rule at its exact boundary. Directed runs cover mid-frame input changes and a frame restart on top of a running frame.

// File: rtl/expo_pkg.sv
package expo_pkg;
    localparam int TIMER_W    = 12;
    localparam int NUM_SLOPES = 2;
    typedef logic [TIMER_W-1:0] timer_t;
    localparam timer_t RST_LEN_MIN = timer_t'(2);
endpackage

// File: rtl/expo_line_timer.sv
module expo_line_timer #(
    parameter int LP_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    input  logic [LP_W-1:0] period,
    output logic            tick
);
    typedef struct packed {
        logic [LP_W-1:0] cyc;
    } lt_state_t;

    lt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cyc == period - LP_W'(1));
        if (restart) begin
            st_d.cyc = '0;
        end else if (run) begin
            st_d.cyc = tick ? '0 : st_q.cyc + LP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the cycle count within a line never reaches the line period
    p_cycle_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run && !restart |-> st_q.cyc < period);
endmodule

// File: rtl/expo_slope_event.sv
module expo_slope_event
    import expo_pkg::*;
(
    input  logic   armed,
    input  timer_t line,
    input  timer_t pos,
    input  timer_t xf_pos,
    output logic   pulse,
    output logic   suppressed
);
    logic enabled, on_line, blocked;

    always_comb begin
        enabled    = (pos != '0);
        on_line    = (line == pos - timer_t'(1));
        blocked    = enabled && (xf_pos != '0) && (pos >= xf_pos);
        pulse      = armed && enabled && on_line && !blocked;
        suppressed = armed && blocked;
    end
endmodule

// File: rtl/expo_pulse_gen.sv
module expo_pulse_gen
    import expo_pkg::*;
#(
    parameter int OVH_W = 8,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [11:0]      rst_len_in,
    input  logic [11:0]      ds_pos_in,
    input  logic [11:0]      ts_pos_in,
    input  logic [11:0]      xf_pos_in,
    input  logic [OVH_W-1:0] row_ovh_in,
    input  logic [PIX_W-1:0] pix_cnt_in,
    output logic             rst_pulse,
    output logic             ds_pulse,
    output logic             ts_pulse,
    output logic             xf_pulse,
    output logic             line_tick,
    output logic             cfg_err
);
    localparam int LP_W = ((OVH_W > PIX_W) ? OVH_W : PIX_W) + 1;

    typedef struct packed {
        logic                         active;
        timer_t                       line;
        timer_t                       rst_len;
        timer_t [NUM_SLOPES-1:0]      slope_pos;
        timer_t                       xf_pos;
        logic [LP_W-1:0]              period;
        logic                         err;
    } pg_state_t;

    pg_state_t st_d, st_q;

    timer_t          slope_in   [NUM_SLOPES];
    logic            slope_hit  [NUM_SLOPES];
    logic            slope_sup  [NUM_SLOPES];
    logic [LP_W-1:0] period_sum;
    logic            tick;
    logic            err_new;

    assign slope_in[0] = ds_pos_in;
    assign slope_in[1] = ts_pos_in;

    expo_line_timer #(.LP_W(LP_W)) line_timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_start),
        .run     (st_q.active),
        .period  (st_q.period),
        .tick    (tick)
    );

    for (genvar g = 0; g < NUM_SLOPES; g++) begin : g_slope
        expo_slope_event slope_i (
            .armed      (st_q.active),
            .line       (st_q.line),
            .pos        (st_q.slope_pos[g]),
            .xf_pos     (st_q.xf_pos),
            .pulse      (slope_hit[g]),
            .suppressed (slope_sup[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        period_sum = LP_W'(row_ovh_in) + LP_W'(pix_cnt_in);
        err_new    = 1'b0;
        for (int i = 0; i < NUM_SLOPES; i++) begin
            if (slope_in[i] != '0 && xf_pos_in != '0 && slope_in[i] >= xf_pos_in)
                err_new = 1'b1;
        end
        if (frame_start) begin
            st_d.active  = 1'b1;
            st_d.line    = '0;
            st_d.rst_len = (rst_len_in < RST_LEN_MIN) ? RST_LEN_MIN : rst_len_in;
            for (int i = 0; i < NUM_SLOPES; i++) st_d.slope_pos[i] = slope_in[i];
            st_d.xf_pos  = xf_pos_in;
            st_d.period  = (period_sum == '0) ? LP_W'(1) : period_sum;
            st_d.err     = err_new;
        end else if (tick && st_q.line != '1) begin
            st_d.line = st_q.line + timer_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_tick = tick;
    assign rst_pulse = st_q.active && (st_q.line < st_q.rst_len - timer_t'(1));
    assign ds_pulse  = slope_hit[0];
    assign ts_pulse  = slope_hit[1];
    assign xf_pulse  = st_q.active && (st_q.xf_pos != '0) &&
                       (st_q.line == st_q.xf_pos - timer_t'(1));
    assign cfg_err   = st_q.err;

    // R1: nothing moves before the first frame
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> !(rst_pulse || ds_pulse || ts_pulse || xf_pulse || line_tick || cfg_err));

    // R2: each tick advances the line index by one
    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !frame_start && st_q.line != '1 |=> st_q.line == $past(st_q.line) + timer_t'(1));

    // R4: the main reset always covers line 0
    p_rst_first_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && st_q.line == '0 |-> rst_pulse);

    // R6: any slope pulse that fires lies before the transfer line
    p_slope_before_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_pulse || ts_pulse) && st_q.xf_pos != '0 |-> st_q.line < st_q.xf_pos - timer_t'(1));

    // R7: the transfer pulse spans its whole line
    p_xfer_whole_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xf_pulse && !tick && !frame_start |=> xf_pulse);

    // R8: a suppressed slope reset is always flagged
    p_err_covers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slope_sup[0] || slope_sup[1]) |-> cfg_err);

    // R9: line period only changes on a frame start
    p_period_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && !frame_start |=> $stable(st_q.period));
endmodule

// File: tb/expo_pulse_gen_tb.sv
`timescale 1ns/1ps
module expo_pulse_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [11:0] rst_len_in = '0, ds_pos_in = '0, ts_pos_in = '0, xf_pos_in = '0;
    logic [7:0]  row_ovh_in = '0, pix_cnt_in = '0;
    logic rst_pulse, ds_pulse, ts_pulse, xf_pulse, line_tick, cfg_err;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    expo_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .rst_len_in(rst_len_in), .ds_pos_in(ds_pos_in), .ts_pos_in(ts_pos_in),
        .xf_pos_in(xf_pos_in), .row_ovh_in(row_ovh_in), .pix_cnt_in(pix_cnt_in),
        .rst_pulse(rst_pulse), .ds_pulse(ds_pulse), .ts_pulse(ts_pulse),
        .xf_pulse(xf_pulse), .line_tick(line_tick), .cfg_err(cfg_err)
    );

    // fields: reset length, dual pos, triple pos, transfer pos, overhead, pixels
    localparam int NV = 6;
    localparam int VEC [NV][6] = '{
        '{3, 5, 7, 9, 3, 2},
        '{0, 0, 0, 4, 1, 1},
        '{1, 3, 0, 0, 2, 0},
        '{6, 4, 8, 6, 0, 3},
        '{2, 2, 2, 3, 0, 0},
        '{4, 6, 5, 6, 1, 2}
    };

    // {tick, rst, ds, ts, xf, err} expected t cycles into a frame
    function automatic logic [5:0] model(int r, int d, int s, int x, int o, int p, int t);
        int  len;
        int  n;
        int  rl;
        bit  dsup, tsup;
        logic [5:0] e;
        len  = o + p;
        if (len < 1) len = 1;
        n    = t / len;
        rl   = (r < 2) ? 2 : r;
        dsup = (d != 0) && (x != 0) && (d >= x);
        tsup = (s != 0) && (x != 0) && (s >= x);
        e[5] = ((t % len) == len - 1);
        e[4] = (n < rl - 1);
        e[3] = (d != 0) && !dsup && (n == d - 1);
        e[2] = (s != 0) && !tsup && (n == s - 1);
        e[1] = (x != 0) && (n == x - 1);
        e[0] = dsup || tsup;
        return e;
    endfunction

    task automatic check(string tag, string ctx, int t, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s t=%0d actual=%0b expected=%0b", tag, ctx, t, got, exp);
        end
    endtask

    task automatic drive(int r, int d, int s, int x, int o, int p);
        rst_len_in = 12'(r); ds_pos_in = 12'(d); ts_pos_in = 12'(s);
        xf_pos_in  = 12'(x); row_ovh_in = 8'(o); pix_cnt_in = 8'(p);
    endtask

    // start a frame at a falling edge, then check ncyc cycles against the model;
    // at cycle chg_at the inputs are scrambled (R9)
    task automatic run_frame(int r, int d, int s, int x, int o, int p,
                             int ncyc, int chg_at, string ctx);
        logic [5:0] e;
        drive(r, d, s, x, o, p);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int t = 0; t < ncyc; t++) begin
            e = model(r, d, s, x, o, p, t);
            check("R2", ctx, t, line_tick, e[5]);
            check((r < 2) ? "R4" : "R3", ctx, t, rst_pulse, e[4]);
            check("R5", ctx, t, ds_pulse, e[3]);
            check("R6", ctx, t, ts_pulse, e[2]);
            check("R7", ctx, t, xf_pulse, e[1]);
            check("R8", ctx, t, cfg_err, e[0]);
            if (t == chg_at) drive(12, 1, 2, 3, 0, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        drive(3, 5, 7, 9, 3, 2);
        repeat (3) @(negedge clk);
        check("R1", "in reset", 0, |{rst_pulse, ds_pulse, ts_pulse, xf_pulse, line_tick, cfg_err}, 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R1", "idle after reset", k,
                  |{rst_pulse, ds_pulse, ts_pulse, xf_pulse, line_tick, cfg_err}, 1'b0);
        end

        for (int v = 0; v < NV; v++) begin
            run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
                      60, -1, $sformatf("vec%0d", v));
        end

        // R9: inputs rewritten mid-frame leave the frame unchanged
        run_frame(3, 5, 7, 9, 3, 2, 60, 3, "R9 mid-frame change");

        // R10: restart on top of a running frame
        run_frame(3, 5, 7, 9, 3, 2, 17, -1, "R10 first frame");
        run_frame(6, 4, 8, 6, 0, 3, 40, -1, "R10 restarted frame");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule